// File: doc/BRIEF.md
# Light-Load Frequency Foldback Controller

This block sets the switching rate of a step-down converter's PWM stage. A system clock is divided down to produce one enable pulse per switching period. At every period boundary the block samples a zero-crossing flag. The flag reports whether the inductor current fell to its near-zero level, about 25 mA, during the period that is ending. When the flag is set for a long enough run of periods, the block moves to a folded rate with twice the period length: half the nominal frequency, for example 215 kHz instead of 430 kHz. When the flag stays clear for an equally long run, the block returns to the nominal rate.

While soft-start is in its first half, the folded rate is forced. A period that is under way always runs to its full length before a new rate takes effect. Dropping the enable returns the block to its idle state and clears its history.

Top module: `fold_ctl`

## Requirements
- R1: After reset, `freq_sel_o` is 0 (nominal rate) and `pwm_en_o` is 0.
- R2: At the nominal rate, `pwm_en_o` is a single-cycle pulse every DIV_NOM clock cycles. The first pulse after enable comes DIV_NOM cycles after the enable is applied.
- R3: At the folded rate (`freq_sel_o` = 1), `pwm_en_o` pulses every 2*DIV_NOM cycles.
- R4: `zx_i` is sampled in the cycle where `pwm_en_o` is 1. If it is 1 at RUN_LEN (default 8) consecutive samples, `freq_sel_o` becomes 1 in the cycle after the last of them.
- R5: At the folded rate, RUN_LEN consecutive samples with `zx_i` = 0, with no forcing during them, return `freq_sel_o` to 0 in the cycle after the last sample.
- R6: A sample of the opposite value breaks a run, and counting starts again from zero.
- R7: Forcing is active when `ss_busy_i` is 1 and the MSB of `ss_prog_i` is 0 (soft-start less than half done). At any boundary while forcing is active, `freq_sel_o` becomes 1. Samples with `zx_i` = 0 taken while forcing is active do not count toward the return to the nominal rate.
- R8: `freq_sel_o` changes only in the cycle after a `pwm_en_o` pulse, or because the enable was removed. No period is shortened.
- R9: While `en_i` is 0, `pwm_en_o` is 0, `freq_sel_o` is cleared to 0, and both run counts are cleared. Re-enabling starts a fresh period and fresh runs.
- R10: Run counts saturate. Runs far longer than RUN_LEN do not wrap, and they do not disturb the current rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Converter enable; low clears all state |
| zx_i | input | 1 | Zero-crossing seen in the current period |
| ss_busy_i | input | 1 | Soft-start in progress |
| ss_prog_i | input | SS_W | Soft-start progress; the MSB set means at least half done |
| freq_sel_o | output | 1 | 0 = nominal rate, 1 = folded (half) rate |
| pwm_en_o | output | 1 | One-cycle pulse at each switching-period boundary |

## Verification
The bench targets runs of exactly RUN_LEN-1 events broken by one opposite sample. A design that does not clear its count on a broken run would fold, or unfold, one period early. Long runs of zero-crossings check for a counter that wraps and falsely reaches its limit again. The bench also checks three further cases, each with a distinct failure mode:
- The bench drops the enable partway through a run and then re-enables. A design that keeps stale counts would fold after only a few new events.
- The bench holds forcing over many quiet periods before releasing it. A design that keeps counting quiet periods during forcing would return to the nominal rate as soon as forcing ends.
- Every period length is measured. A rate change applied in mid-period shows up as a truncated or stretched interval.

// File: rtl/fold_pkg.sv
package fold_pkg;
  typedef enum logic {
    FREQ_NOM  = 1'b0,
    FREQ_HALF = 1'b1
  } freq_e;
endpackage

// File: rtl/fold_div.sv
// Period divider: boundary pulse every DIV or 2*DIV cycles
module fold_div #(
  parameter int DIV = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic half_i,
  output logic tick_o
);
  localparam int CW = $clog2(2 * DIV);
  localparam logic [CW-1:0] LIM_NOM  = CW'(DIV - 1);
  localparam logic [CW-1:0] LIM_HALF = CW'(2 * DIV - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;

  assign lim    = half_i ? LIM_HALF : LIM_NOM;
  assign tick_o = en_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!en_i)  cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/fold_run.sv
// Saturating count of consecutive hits; full_o flags the completing hit
module fold_run #(
  parameter int LEN = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic step_i,
  input  logic hit_i,
  output logic full_o
);
  localparam int CW = (LEN > 2) ? $clog2(LEN) : 1;
  localparam logic [CW-1:0] TOP = CW'(LEN - 1);

  logic [CW-1:0] cnt_q;

  assign full_o = step_i && hit_i && (cnt_q == TOP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (step_i) begin
      if (!hit_i)            cnt_q <= '0;
      else if (cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/fold_ctl.sv
module fold_ctl #(
  parameter int DIV_NOM = 8,
  parameter int RUN_LEN = 8,
  parameter int SS_W    = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            zx_i,
  input  logic            ss_busy_i,
  input  logic [SS_W-1:0] ss_prog_i,
  output logic            freq_sel_o,
  output logic            pwm_en_o
);
  import fold_pkg::*;

  localparam int NDIR = 2;  // 0: toward fold, 1: toward nominal

  freq_e     freq_q;
  logic      tick;
  logic      forced;
  logic [NDIR-1:0] run_clr, run_hit, run_full;

  assign forced = ss_busy_i && !ss_prog_i[SS_W-1];

  fold_div #(.DIV(DIV_NOM)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .half_i (freq_q == FREQ_HALF),
    .tick_o (tick)
  );

  assign run_clr[0] = !en_i;
  assign run_hit[0] = zx_i;
  assign run_clr[1] = !en_i || forced;  // quiet periods ignored while forced
  assign run_hit[1] = !zx_i;

  for (genvar d = 0; d < NDIR; d++) begin : g_run
    fold_run #(.LEN(RUN_LEN)) u_run (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (run_clr[d]),
      .step_i (tick),
      .hit_i  (run_hit[d]),
      .full_o (run_full[d])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     freq_q <= FREQ_NOM;
    else if (!en_i)  freq_q <= FREQ_NOM;
    else if (tick) begin
      if (forced)                                  freq_q <= FREQ_HALF;
      else if (freq_q == FREQ_NOM  && run_full[0]) freq_q <= FREQ_HALF;
      else if (freq_q == FREQ_HALF && run_full[1]) freq_q <= FREQ_NOM;
    end
  end

  assign freq_sel_o = (freq_q == FREQ_HALF);
  assign pwm_en_o   = tick;
endmodule

// File: rtl/fold_ctl_chk.sv
module fold_ctl_chk #(
  parameter int SS_W = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            en_i,
  input logic            zx_i,
  input logic            ss_busy_i,
  input logic [SS_W-1:0] ss_prog_i,
  input logic            freq_sel_o,
  input logic            pwm_en_o
);
  logic forced;
  assign forced = ss_busy_i && !ss_prog_i[SS_W-1];

  p_quiet_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !pwm_en_o);
  p_off_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !freq_sel_o);
  p_single_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwm_en_o |=> !pwm_en_o);
  p_change_at_edge_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !pwm_en_o) |=> $stable(freq_sel_o));
  p_forced_fold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && pwm_en_o && forced) |=> freq_sel_o);
  p_enter_needs_zx_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && pwm_en_o && !freq_sel_o && !zx_i && !forced) |=> !freq_sel_o);
  p_exit_needs_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && pwm_en_o && freq_sel_o && (zx_i || forced)) |=> freq_sel_o);
endmodule

bind fold_ctl fold_ctl_chk #(.SS_W(SS_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .zx_i       (zx_i),
  .ss_busy_i  (ss_busy_i),
  .ss_prog_i  (ss_prog_i),
  .freq_sel_o (freq_sel_o),
  .pwm_en_o   (pwm_en_o)
);

// File: tb/fold_ctl_bench.sv
module fold_ctl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DIV  = 8;
  localparam int RUN  = 8;
  localparam int SS_W = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i = 1'b0;
  logic zx_i = 1'b0;
  logic ss_busy_i = 1'b0;
  logic [SS_W-1:0] ss_prog_i = '0;
  logic freq_sel_o, pwm_en_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // reference model state
  bit m_fold = 1'b0;
  int m_in = 0;
  int m_out = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  fold_ctl #(.DIV_NOM(DIV), .RUN_LEN(RUN), .SS_W(SS_W)) u_fold_ctl (
    .clk_i, .rst_ni, .en_i, .zx_i, .ss_busy_i, .ss_prog_i, .freq_sel_o, .pwm_en_o
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit is_forced();
    return ss_busy_i && !ss_prog_i[SS_W-1];
  endfunction

  task automatic model_step(input bit zx, input bit frc);
    bit in_full, out_full;
    in_full  = zx && (m_in == RUN-1);
    out_full = !zx && !frc && (m_out == RUN-1);
    m_in  = zx ? ((m_in < RUN-1) ? m_in + 1 : m_in) : 0;
    m_out = (zx || frc) ? 0 : ((m_out < RUN-1) ? m_out + 1 : m_out);
    if (frc)                  m_fold = 1'b1;
    else if (!m_fold && in_full)  m_fold = 1'b1;
    else if (m_fold && out_full)  m_fold = 1'b0;
  endtask

  function automatic void model_clear();
    m_fold = 1'b0; m_in = 0; m_out = 0;
  endfunction

  // Entered at a negedge where a new period has just begun
  task automatic run_period(input bit zx, input string req);
    int n;
    int exp_gap;
    zx_i = zx;
    n = 1;
    while (!pwm_en_o && n < 100) begin
      @(negedge clk_i);
      n++;
    end
    exp_gap = m_fold ? 2*DIV : DIV;
    check(n == exp_gap, m_fold ? "R3 R8 period length" : "R2 R8 period length", n, exp_gap);
    model_step(zx, is_forced());
    @(negedge clk_i);
    check(freq_sel_o == m_fold, req, int'(freq_sel_o), int'(m_fold));
  endtask

  task automatic run_many(input int cnt, input bit zx, input string req);
    for (int i = 0; i < cnt; i++) run_period(zx, req);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk_i);
    check(freq_sel_o == 1'b0, "R1 reset freq_sel", int'(freq_sel_o), 0);
    check(pwm_en_o == 1'b0, "R1 reset pwm_en", int'(pwm_en_o), 0);
    @(negedge clk_i); rst_ni = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk_i);
      check(pwm_en_o == 1'b0, "R9 idle no pulse", int'(pwm_en_o), 0);
    end

    en_i = 1'b1;
    run_many(10, 1'b0, "R2 nominal stays");
    // R6: broken runs
    run_many(7, 1'b1, "R6 seven zx no fold");
    run_period(1'b0, "R6 break");
    run_many(7, 1'b1, "R6 seven after break");
    run_period(1'b1, "R4 eighth zx folds");
    check(freq_sel_o == 1'b1, "R4 folded", int'(freq_sel_o), 1);
    // R10 saturation
    run_many(20, 1'b1, "R10 long zx run");
    run_many(7, 1'b0, "R6 seven quiet no exit");
    run_period(1'b1, "R6 break quiet");
    run_many(7, 1'b0, "R5 quiet run");
    run_period(1'b0, "R5 eighth quiet exits");
    check(freq_sel_o == 1'b0, "R5 nominal again", int'(freq_sel_o), 0);

    // R9 disable mid-run clears counts
    run_many(5, 1'b1, "R9 partial run");
    repeat (3) @(negedge clk_i);
    en_i = 1'b0;
    model_clear();
    for (int i = 0; i < 2*DIV + 2; i++) begin
      @(negedge clk_i);
      check(pwm_en_o == 1'b0, "R9 disabled no pulse", int'(pwm_en_o), 0);
    end
    en_i = 1'b1;
    run_many(7, 1'b1, "R9 counts cleared");
    run_period(1'b1, "R9 R4 fresh run folds");
    @(negedge clk_i);
    en_i = 1'b0;
    model_clear();
    @(negedge clk_i);
    check(freq_sel_o == 1'b0, "R9 disable clears fold", int'(freq_sel_o), 0);
    en_i = 1'b1;

    // R7 forcing
    ss_busy_i = 1'b1; ss_prog_i = 8'h10;
    run_period(1'b0, "R7 forced fold");
    run_many(10, 1'b0, "R7 forced hold");
    ss_prog_i = 8'h80;
    run_many(7, 1'b0, "R7 quiet not counted while forced");
    run_period(1'b0, "R7 R5 exit after release");
    ss_busy_i = 1'b0; ss_prog_i = '0;

    // random mix
    for (int blk = 0; blk < 40; blk++) begin
      int bias, len;
      bias = $urandom_range(0, 3);
      len  = $urandom_range(3, 14);
      ss_busy_i = ($urandom_range(0, 9) == 0);
      ss_prog_i = SS_W'($urandom);
      for (int i = 0; i < len; i++) begin
        bit z;
        z = ($urandom_range(0, 3) < bias) ^ ($urandom_range(0, 15) == 0);
        run_period(z, "R4 R5 R6 R7 random");
      end
    end
    ss_busy_i = 1'b0;
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk_i);
      cyc++;
    end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected done", cyc);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule